// File: doc/BRIEF.md
# Memory-Mapped SPI Flash Read Engine

This block serves reads from a memory-mapped window by turning each one into a complete serial flash read command. Each chip select has its own setup word. The setup word describes the whole command: the opcode byte, how many address bytes follow it, how many dummy bytes come next, and how many lanes carry the returned data. Because of this, any flash read opcode can be used behind the window without software taking part in each access.

A separate switch bit gives the serial pins to this engine. While the switch is off, every window read is refused. A bus read is held (ready low) while the engine runs the command:

- chip select low;
- opcode, address and dummy clocks on lane 0;
- data captured on one, two or four lanes.

The engine then returns the assembled word in a one-cycle ready pulse, and chip select is already high in that cycle. Reads that fall outside the window, or that ask for an unsupported length, get an immediate error response and cause no serial activity.

Top module: `mmspi_read_engine`

## Requirements
- R1: Setup word bits 7:0 hold the read opcode. After a read is accepted, the opcode is the first thing shifted out on `spi_mosi`, most significant bit first.
- R2: Setup bits 9:8 hold the number of address bytes minus one (1 to 4 bytes). The low bytes of `rd_addr`, zero-extended, follow the opcode, most significant byte and bit first.
- R3: Setup bits 11:10 hold the number of dummy bytes (0 to 3). Each dummy byte gives 8 clocks with `spi_mosi` at 0, and `spi_mosi` also stays 0 during the data phase.
- R4: Setup bits 13:12 select the data lanes. 0 means one lane, read on `spi_io_in[1]`. 1 means two lanes, `spi_io_in[1:0]`, with bit 1 carrying the earlier bit. 3 means four lanes, `spi_io_in[3:0]`, with bit 3 carrying the earliest bit. Code 2 behaves as one lane.
- R5: The setup words for chip selects 0 to 3 are written at `cfg_addr` 0 to 3. `win_sel` picks which word and which chip select a read uses. Only `spi_cs_n[win_sel]` goes low, and never more than one chip select at a time.
- R6: Bit 0 of a write to `cfg_addr` 4 sets the switch, which appears on `spi_own`. While the switch is 0, a read gets an error response and no chip select goes low.
- R7: A read with `rd_nbytes` of 0, `rd_nbytes` above 4, or `rd_addr + rd_nbytes` greater than the window size (default 4096) gets `rd_ready` and `rd_err` in the next cycle, with no serial activity.
- R8: An accepted read gives `rd_ready` exactly 2*(H+D)+1 cycles after the accepting edge, where H = 8*(1 + address bytes + dummy bytes) and D = 8*bytes/lanes. Chip select is low for the 2*(H+D) cycles before that and high in the ready cycle.
- R9: The first byte received is returned in `rd_data[7:0]`, the next in `[15:8]`, and so on. Bytes beyond `rd_nbytes` read as 0.
- R10: `spi_sclk` idles low and each bit takes one low cycle followed by one high cycle. `spi_mosi` changes only while `spi_sclk` is low, and data lanes are sampled at the end of the high cycle.
- R11: The setup word is captured when a read is accepted. Rewriting that setup word during the read does not change the read that is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | 0..3 setup words, 4 switch |
| cfg_wdata | input | 32 | Configuration write data |
| win_sel | input | 2 | Chip select used for window reads |
| rd_req | input | 1 | Read request, held until `rd_ready` |
| rd_addr | input | 16 | Byte offset in the window |
| rd_nbytes | input | 3 | Bytes requested (1..4) |
| rd_ready | output | 1 | One-cycle completion pulse |
| rd_err | output | 1 | Read refused, valid with `rd_ready` |
| rd_data | output | 32 | Assembled read data |
| spi_own | output | 1 | Engine owns the serial pins |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 4 | Active-low chip selects |
| spi_mosi | output | 1 | Lane 0 output |
| spi_io_in | input | 4 | Data lanes from the flash |

## Verification
The bench programs each chip select with a different command shape:

- a plain one-lane read with no dummy bytes;
- a dual read with one dummy byte;
- a quad read with four address bytes;
- a one-address-byte quad read with three dummy bytes;
- the reserved lane code.

Taken together, these separate wrong field positions, wrong lane order and wrong byte order. The bench's flash model keeps the lanes that should go unused at 1, so a read taken from the wrong lane shows up in the data. Window boundary reads (exactly fitting, one byte over, zero length) separate the acceptance rule from off-by-one errors. A setup rewrite during a running read shows whether the fields are latched at acceptance.

// File: rtl/mmspi_pkg.sv
package mmspi_pkg;

   // Setup word, packed so that a cast from bits 13:0 lands each field in place.
   typedef struct packed {
      logic [1:0] lmode;   // 13:12 data lane code
      logic [1:0] dummy;   // 11:10 dummy byte count
      logic [1:0] abytes;  // 9:8   address bytes minus one
      logic [7:0] opcode;  // 7:0
   } setup_t;

   localparam int SETUP_W = $bits(setup_t);

   typedef enum logic [1:0] {
      LM_ONE  = 2'd0,
      LM_TWO  = 2'd1,
      LM_RSVD = 2'd2,
      LM_FOUR = 2'd3
   } lane_code_e;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_HDR,
      SQ_DATA,
      SQ_DONE,
      SQ_ERR
   } seq_state_e;

   function automatic int lanes_of(logic [1:0] code);
      case (code)
         LM_FOUR: return 4;
         LM_TWO:  return 2;
         default: return 1;
      endcase
   endfunction

endpackage

// File: rtl/mmspi_cfg_regs.sv
module mmspi_cfg_regs
   import mmspi_pkg::*;
#(
   parameter int NUM_CS  = 4,
   parameter int CS_W    = 2,
   parameter int SW_ADDR = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [2:0]      addr,
   input  logic [31:0]     wdata,
   input  logic [CS_W-1:0] sel,
   output setup_t          sel_setup,
   output logic            mm_on
);

   setup_t slots [NUM_CS];

   logic unused_hi;
   assign unused_hi = ^wdata[31:SETUP_W];

   for (genvar g = 0; g < NUM_CS; g++) begin : g_slot
      setup_t slot_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot_q <= '0;
         else if (we && addr == 3'(g))
            slot_q <= setup_t'(wdata[SETUP_W-1:0]);
      end
      assign slots[g] = slot_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mm_on <= 1'b0;
      else if (we && addr == 3'(SW_ADDR))
         mm_on <= wdata[0];
   end

   always_comb begin
      if (int'(sel) < NUM_CS)
         sel_setup = slots[sel];
      else
         sel_setup = '0;
   end

   assert_switch_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == 3'(SW_ADDR)) |=> (mm_on == $past(wdata[0])))
      else $error("switch bit did not follow write");

endmodule

// File: rtl/mmspi_req_check.sv
module mmspi_req_check #(
   parameter int NUM_CS    = 4,
   parameter int CS_W      = 2,
   parameter int ADDR_W    = 16,
   parameter int NB_W      = 3,
   parameter int MAX_BYTES = 4,
   parameter int WIN_SIZE  = 4096
) (
   input  logic              mm_on,
   input  logic [CS_W-1:0]   sel,
   input  logic [ADDR_W-1:0] addr,
   input  logic [NB_W-1:0]   nbytes,
   output logic              ok
);

   localparam int SUM_W = ADDR_W + 1;

   logic [SUM_W-1:0] end_off;
   logic             len_ok, win_ok, sel_ok;

   always_comb begin
      end_off = {1'b0, addr} + SUM_W'(nbytes);
      len_ok  = (nbytes != '0) && (int'(nbytes) <= MAX_BYTES);
      win_ok  = end_off <= SUM_W'(WIN_SIZE);
      sel_ok  = int'(sel) < NUM_CS;
      ok      = mm_on && len_ok && win_ok && sel_ok;
   end

endmodule

// File: rtl/mmspi_seq.sv
module mmspi_seq
   import mmspi_pkg::*;
#(
   parameter int NUM_CS    = 4,
   parameter int CS_W      = 2,
   parameter int ADDR_W    = 16,
   parameter int NB_W      = 3,
   parameter int MAX_BYTES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              ok,
   input  logic [CS_W-1:0]   sel,
   input  setup_t            setup,
   input  logic [ADDR_W-1:0] addr,
   input  logic [NB_W-1:0]   nbytes,
   output logic              ready,
   output logic              err,
   output logic              cap_clr,
   output logic              cap_en,
   output logic [1:0]        lmode_q,
   output logic [NB_W-1:0]   nbytes_q,
   output logic              sclk,
   output logic [NUM_CS-1:0] cs_n,
   output logic              mosi
);

   localparam int HDR_BITS = 40;
   localparam int HCNT_W   = 7;
   localparam int DCNT_W   = $clog2(8 * MAX_BYTES + 1);

   seq_state_e          state;
   logic                phase;
   logic [HDR_BITS-1:0] sreg;
   logic [HCNT_W-1:0]   hdr_left;
   logic [DCNT_W-1:0]   dat_left;
   logic [HCNT_W-1:0]   hdr_beats;
   logic [DCNT_W-1:0]   dat_beats;
   logic [31:0]         addr_al;

   always_comb begin
      addr_al   = 32'(addr) << (8 * (3 - int'(setup.abytes)));
      hdr_beats = HCNT_W'(8 * (int'(setup.abytes) + 2 + int'(setup.dummy)));
      dat_beats = DCNT_W'((8 * int'(nbytes)) / lanes_of(setup.lmode));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= SQ_IDLE;
         phase    <= 1'b0;
         sclk     <= 1'b0;
         cs_n     <= '1;
         sreg     <= '0;
         hdr_left <= '0;
         dat_left <= '0;
         lmode_q  <= '0;
         nbytes_q <= '0;
      end else begin
         case (state)
            SQ_IDLE: begin
               if (req) begin
                  if (ok) begin
                     state    <= SQ_HDR;
                     cs_n     <= ~(NUM_CS'(1) << sel);
                     sreg     <= {setup.opcode, addr_al};
                     hdr_left <= hdr_beats;
                     dat_left <= dat_beats;
                     lmode_q  <= setup.lmode;
                     nbytes_q <= nbytes;
                     phase    <= 1'b0;
                     sclk     <= 1'b0;
                  end else begin
                     state <= SQ_ERR;
                  end
               end
            end
            SQ_HDR: begin
               if (!phase) begin
                  phase <= 1'b1;
                  sclk  <= 1'b1;
               end else begin
                  phase    <= 1'b0;
                  sclk     <= 1'b0;
                  sreg     <= {sreg[HDR_BITS-2:0], 1'b0};
                  hdr_left <= hdr_left - 1'b1;
                  if (hdr_left == HCNT_W'(1))
                     state <= SQ_DATA;
               end
            end
            SQ_DATA: begin
               if (!phase) begin
                  phase <= 1'b1;
                  sclk  <= 1'b1;
               end else begin
                  phase    <= 1'b0;
                  sclk     <= 1'b0;
                  sreg     <= {sreg[HDR_BITS-2:0], 1'b0};
                  dat_left <= dat_left - 1'b1;
                  if (dat_left == DCNT_W'(1)) begin
                     state <= SQ_DONE;
                     cs_n  <= '1;
                  end
               end
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

   assign mosi    = sreg[HDR_BITS-1];
   assign ready   = (state == SQ_DONE) || (state == SQ_ERR);
   assign err     = (state == SQ_ERR);
   assign cap_clr = (state == SQ_IDLE) && req && ok;
   assign cap_en  = (state == SQ_DATA) && phase;

   assert_one_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cs_n))
      else $error("more than one chip select low");

   assert_sclk_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (&cs_n) |-> !sclk)
      else $error("serial clock high with no chip select");

   assert_mosi_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
      sclk |-> $stable(mosi))
      else $error("lane 0 moved while clock high");

endmodule

// File: rtl/mmspi_capture.sv
module mmspi_capture #(
   parameter int MAX_BYTES = 4,
   parameter int NB_W      = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clr,
   input  logic                   en,
   input  logic [1:0]             lmode,
   input  logic [3:0]             io_in,
   input  logic [NB_W-1:0]        nbytes,
   output logic [8*MAX_BYTES-1:0] data_o
);

   localparam int DW = 8 * MAX_BYTES;

   logic [DW-1:0] shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         shreg <= '0;
      else if (clr)
         shreg <= '0;
      else if (en) begin
         case (lmode)
            2'd3:    shreg <= {shreg[DW-5:0], io_in[3:0]};
            2'd1:    shreg <= {shreg[DW-3:0], io_in[1:0]};
            default: shreg <= {shreg[DW-2:0], io_in[1]};
         endcase
      end
   end

   // Received stream is big-endian in the low 8*nbytes bits; the first byte goes to lane 0 of the word.
   for (genvar k = 0; k < MAX_BYTES; k++) begin : g_byte
      logic [DW-1:0] moved;
      always_comb begin
         moved = '0;
         if (k < int'(nbytes))
            moved = shreg >> (8 * (int'(nbytes) - 1 - k));
      end
      assign data_o[8*k +: 8] = moved[7:0];
   end

endmodule

// File: rtl/mmspi_read_engine.sv
module mmspi_read_engine
   import mmspi_pkg::*;
#(
   parameter int NUM_CS    = 4,
   parameter int ADDR_W    = 16,
   parameter int WIN_SIZE  = 4096,
   parameter int MAX_BYTES = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_we,
   input  logic [2:0]             cfg_addr,
   input  logic [31:0]            cfg_wdata,
   input  logic [1:0]             win_sel,
   input  logic                   rd_req,
   input  logic [ADDR_W-1:0]      rd_addr,
   input  logic [2:0]             rd_nbytes,
   output logic                   rd_ready,
   output logic                   rd_err,
   output logic [8*MAX_BYTES-1:0] rd_data,
   output logic                   spi_own,
   output logic                   spi_sclk,
   output logic [NUM_CS-1:0]      spi_cs_n,
   output logic                   spi_mosi,
   input  logic [3:0]             spi_io_in
);

   localparam int CS_W = 2;
   localparam int NB_W = 3;

   if (NUM_CS < 2 || NUM_CS > 4) begin : g_bad_cs
      $error("NUM_CS must be 2..4");
   end
   if (MAX_BYTES < 1 || MAX_BYTES > 4) begin : g_bad_bytes
      $error("MAX_BYTES must be 1..4");
   end
   if (ADDR_W > 32 || WIN_SIZE < 1 || WIN_SIZE > (2 ** ADDR_W)) begin : g_bad_win
      $error("window does not fit the address width");
   end

   setup_t          sel_setup;
   logic            mm_on;
   logic            acc_ok;
   logic            cap_clr, cap_en;
   logic [1:0]      lmode_q;
   logic [NB_W-1:0] nbytes_q;

   mmspi_cfg_regs #(.NUM_CS(NUM_CS), .CS_W(CS_W), .SW_ADDR(4)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
      .sel(win_sel), .sel_setup(sel_setup), .mm_on(mm_on)
   );

   mmspi_req_check #(
      .NUM_CS(NUM_CS), .CS_W(CS_W), .ADDR_W(ADDR_W), .NB_W(NB_W),
      .MAX_BYTES(MAX_BYTES), .WIN_SIZE(WIN_SIZE)
   ) u_chk (
      .mm_on(mm_on), .sel(win_sel), .addr(rd_addr), .nbytes(rd_nbytes), .ok(acc_ok)
   );

   mmspi_seq #(
      .NUM_CS(NUM_CS), .CS_W(CS_W), .ADDR_W(ADDR_W), .NB_W(NB_W), .MAX_BYTES(MAX_BYTES)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .req(rd_req), .ok(acc_ok), .sel(win_sel),
      .setup(sel_setup), .addr(rd_addr), .nbytes(rd_nbytes),
      .ready(rd_ready), .err(rd_err), .cap_clr(cap_clr), .cap_en(cap_en),
      .lmode_q(lmode_q), .nbytes_q(nbytes_q),
      .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi)
   );

   mmspi_capture #(.MAX_BYTES(MAX_BYTES), .NB_W(NB_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .clr(cap_clr), .en(cap_en), .lmode(lmode_q),
      .io_in(spi_io_in), .nbytes(nbytes_q), .data_o(rd_data)
   );

   assign spi_own = mm_on;

   assert_ready_cs_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ready |-> (&spi_cs_n))
      else $error("chip select low in ready cycle");

   assert_err_no_serial_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_err |-> (!spi_sclk && (&spi_cs_n)))
      else $error("serial activity on refused read");

   assert_no_own_no_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!spi_own && $past(!spi_own)) |-> (&spi_cs_n))
      else $error("chip select low while pins not owned");

endmodule

// File: tb/mmspi_read_engine_test.sv
module mmspi_read_engine_test;

   localparam int WIN = 4096;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_we;
   logic [2:0]  cfg_addr;
   logic [31:0] cfg_wdata;
   logic [1:0]  win_sel;
   logic        rd_req;
   logic [15:0] rd_addr;
   logic [2:0]  rd_nbytes;
   logic        rd_ready, rd_err, spi_own, spi_sclk, spi_mosi;
   logic [31:0] rd_data;
   logic [3:0]  spi_cs_n;
   logic [3:0]  spi_io_in;

   always #5 clk = ~clk;

   mmspi_read_engine uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .win_sel(win_sel), .rd_req(rd_req), .rd_addr(rd_addr), .rd_nbytes(rd_nbytes),
      .rd_ready(rd_ready), .rd_err(rd_err), .rd_data(rd_data), .spi_own(spi_own),
      .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_io_in(spi_io_in)
   );

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 0;

   // Behavioural flash model, sampled away from the active edge
   int           rises = 0;
   logic [127:0] cap   = '0;
   int           f_nout = 1000;
   int           f_lanes = 1;
   int           f_nb = 0;
   logic [7:0]   f_bytes [4];
   logic         prev_mosi = 1'b0;
   int           hi_viol = 0;

   function automatic logic stream_bit(int i);
      return f_bytes[i / 8][7 - (i % 8)];
   endfunction

   initial spi_io_in = 4'hF;

   always @(negedge clk) begin
      if (spi_sclk) begin
         rises = rises + 1;
         cap   = {cap[126:0], spi_mosi};
         if (spi_mosi !== prev_mosi) hi_viol = hi_viol + 1;
      end else if (rises >= f_nout) begin
         logic [3:0] v;
         int k;
         v = 4'hF;
         k = rises - f_nout;
         for (int j = 0; j < f_lanes; j++) begin
            int idx;
            int lane;
            idx  = k * f_lanes + j;
            lane = (f_lanes == 1) ? 1 : (f_lanes - 1 - j);
            if (idx < 8 * f_nb) v[lane] = stream_bit(idx);
         end
         spi_io_in = v;
      end else begin
         spi_io_in = 4'hF;
      end
      prev_mosi = spi_mosi;
   end

   task automatic check(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic cfg_write(int a, logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   function automatic logic [31:0] setup_word(int op, int ab_m1, int nd, int mode);
      return 32'(op) | (32'(ab_m1) << 8) | (32'(nd) << 10) | (32'(mode) << 12);
   endfunction

   task automatic refused(int sel, int addr, int nb, string req);
      rises = 0;
      @(negedge clk);
      win_sel = 2'(sel); rd_addr = 16'(addr); rd_nbytes = 3'(nb); rd_req = 1'b1;
      @(negedge clk);
      check(rd_ready === 1'b1 && rd_err === 1'b1 && spi_cs_n === 4'hF, req,
            "error response", {rd_ready, rd_err, spi_cs_n}, {1'b1, 1'b1, 4'hF});
      rd_req = 1'b0;
      @(negedge clk);
      check(rises == 0 && rd_ready === 1'b0, req, "no serial clocks", 128'(rises), 0);
   endtask

   // Full read; poke rewrites this chip select's setup word during the transfer
   task automatic good_read(int sel, int addr, int nb, int op, int ab_m1, int nd, int mode,
                            bit poke, string req);
      int L, nout, ndat, dly, bad;
      logic [127:0] exp_hdr;
      logic [31:0]  exp_data;
      L    = (mode == 3) ? 4 : (mode == 1) ? 2 : 1;
      nout = 8 * (1 + ab_m1 + 1 + nd);
      ndat = nb * 8 / L;
      dly  = 2 * (nout + ndat) + 1;
      exp_data = '0;
      for (int k = 0; k < 4; k++) begin
         f_bytes[k] = 8'((addr + k) * 73 + 53);
         if (k < nb) exp_data[8*k +: 8] = f_bytes[k];
      end
      exp_hdr = 128'(op);
      for (int b = ab_m1; b >= 0; b--) exp_hdr = (exp_hdr << 8) | 128'((addr >> (8 * b)) & 255);
      exp_hdr = exp_hdr << (8 * nd);
      exp_hdr = exp_hdr << ndat;
      f_nout = nout; f_lanes = L; f_nb = nb;
      rises = 0; cap = '0; hi_viol = 0; bad = 0;
      @(negedge clk);
      win_sel = 2'(sel); rd_addr = 16'(addr); rd_nbytes = 3'(nb); rd_req = 1'b1;
      for (int c = 1; c <= dly; c++) begin
         @(negedge clk);
         if (poke && c == 1) begin
            cfg_we = 1'b1; cfg_addr = 3'(sel); cfg_wdata = setup_word(8'hA5, 0, 0, 0);
         end
         if (poke && c == 2) cfg_we = 1'b0;
         if (c < dly) begin
            if (spi_cs_n !== ~(4'b1 << sel) || rd_ready !== 1'b0) bad++;
         end else begin
            if (spi_cs_n !== 4'hF || rd_ready !== 1'b1) bad++;
         end
      end
      check(bad == 0, {req, " R8 R5"}, "cs/ready timing mismatches", 128'(bad), 0);
      check(rd_err === 1'b0, {req, " R8"}, "no error", 128'(rd_err), 0);
      check(rd_data === exp_data, {req, " R9 R4"}, "data", 128'(rd_data), 128'(exp_data));
      rd_req = 1'b0;
      check(rises == nout + ndat, {req, " R3"}, "clock count", 128'(rises), 128'(nout + ndat));
      check(cap === exp_hdr, {req, " R1 R2 R3"}, "lane 0 bits", cap, exp_hdr);
      check(hi_viol == 0, {req, " R10"}, "lane 0 stable while clock high", 128'(hi_viol), 0);
      f_nout = 1000;
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
      win_sel = '0; rd_req = 1'b0; rd_addr = '0; rd_nbytes = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(spi_own === 1'b0 && spi_cs_n === 4'hF && spi_sclk === 1'b0 && rd_ready === 1'b0,
            "R6 R10", "reset state", {spi_own, spi_cs_n, spi_sclk, rd_ready}, {1'b0, 4'hF, 2'b0});

      // R5: setup words at cfg addresses 0..3
      cfg_write(0, setup_word(8'h03, 2, 0, 0));
      cfg_write(1, setup_word(8'h3B, 2, 1, 1));
      cfg_write(2, setup_word(8'h6C, 3, 1, 3));
      cfg_write(3, setup_word(8'hEB, 0, 3, 3));

      refused(0, 16, 4, "R6 switch off");

      cfg_write(4, 32'h1);
      check(spi_own === 1'b1, "R6", "switch on", 128'(spi_own), 1);

      good_read(0, 16'h0123, 4, 8'h03, 2, 0, 0, 0, "R1 single");
      good_read(1, 16'h0A5C, 2, 8'h3B, 2, 1, 1, 0, "R4 dual");
      good_read(2, 16'h0F00, 4, 8'h6C, 3, 1, 3, 0, "R2 quad four-byte address");
      good_read(3, 16'h00C7, 1, 8'hEB, 0, 3, 3, 0, "R3 three dummy bytes");
      good_read(3, 16'h0044, 3, 8'hEB, 0, 3, 3, 0, "R9 three bytes");

      cfg_write(3, setup_word(8'h0B, 1, 1, 2));
      good_read(3, 16'h0210, 2, 8'h0B, 1, 1, 2, 0, "R4 reserved code");

      // R7 window boundaries and lengths
      good_read(0, WIN - 4, 4, 8'h03, 2, 0, 0, 0, "R7 exact fit");
      refused(0, WIN - 3, 4, "R7 one byte over");
      refused(1, 16, 0, "R7 zero length");
      refused(1, 16, 5, "R7 length above four");

      // R11: rewrite during transfer, then the new word takes effect
      good_read(1, 16'h0300, 2, 8'h3B, 2, 1, 1, 1, "R11 in-flight");
      good_read(1, 16'h0007, 1, 8'hA5, 0, 0, 0, 0, "R11 new word");

      cfg_write(4, 32'h0);
      check(spi_own === 1'b0, "R6", "switch off", 128'(spi_own), 0);
      refused(2, 16, 2, "R6 switch off again");

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule